// File: doc/BRIEF.md
# Stepped Soft Mute Attenuator

This block is a digital volume stage for one stereo PCM stream. Every accepted sample pair is multiplied by a linear gain taken from an attenuation code. The code counts quarter-decibel steps of attenuation, and the all-ones code means complete silence. The block does not jump to a new setting. It walks its internal level one quarter-decibel step at a time toward the requested code. The time spent on each step is a programmable number of sample periods.

An upstream serial-audio receiver delivers a strobe at the sample rate with signed 24-bit left and right words. Control logic holds the attenuation code and the step-rate code on static inputs. The block returns the scaled pair one clock after the strobe, with its own strobe. A level flag reports when the walk has finished.

The internal level has 257 positions. Positions 0 to 255 are finite gains of 10^(-n/80). Position 256 is mute. The all-ones code targets position 256, so a walk into mute always passes through the -63.75 dB step.

Top module: `soft_atten`

## Requirements
- R1: With level 0 (attenuation code 0x00) the output sample equals the input sample bit for bit.
- R2: With attenuation code 0xFF reached, both output samples are exactly zero.
- R3: The gain at level n (0..255) is 10^(-n/80), held as an unsigned fraction with 23 fraction bits, so each code step adds 0.25 dB of attenuation.
- R4: With step-rate code 0 the level moves to the target on the same strobe, and that strobe's sample already uses the new gain.
- R5: Step-rate codes 1, 2, 3, 4 and 5 give a dwell of 1, 2, 4, 8 and 16 strobes per step. Codes 6 and 7 behave as code 5. The level changes by at most one position per strobe.
- R6: A walk from code c into mute takes (256 - c) x dwell strobes before the level flag rises.
- R7: If the target changes during a walk, the walk continues from the current level toward the new target. The dwell count is kept.
- R8: Left and right always use the same gain on the same strobe.
- R9: done_o is high exactly when the current level equals the level selected by atten_i. It is high after reset with code 0.
- R10: valid_o follows valid_i with one clock of latency. Without a strobe the level, the counter and the output samples hold.
- R11: Products are rounded to nearest, with ties toward plus infinity, and then saturated to signed 24 bits. For example, 1 at -6 dB gives 1, and -1 gives -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| left_i | input | 24 | Left input sample, signed |
| right_i | input | 24 | Right input sample, signed |
| atten_i | input | 8 | Target attenuation code, 0.25 dB per LSB, 0xFF is mute |
| rate_i | input | 3 | Step-rate code: 0 is immediate, 1..5 give a dwell of 2^(code-1) strobes |
| valid_o | output | 1 | Output strobe, one clock after valid_i |
| left_o | output | 24 | Scaled left sample, signed |
| right_o | output | 24 | Scaled right sample, signed |
| done_o | output | 1 | Level equals target |

## Verification
A level step and the multiply happen on the same strobe. The sample that arrives on a stepping strobe must already use the updated gain. A mistake here shifts the whole gain sequence by one sample. The bench causes this collision on every ramp, on a change of target in the middle of a walk, and when the step rate drops below the dwell count already reached. A behavioural model advances its own level before it scales the sample, and the bench compares both outputs and the level flag on every clock.

// File: rtl/soft_atten_pkg.sv
package soft_atten_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned NUM_CODES = 1 << CODE_W;
  localparam int unsigned LVL_W     = CODE_W + 1;
  localparam int unsigned GAIN_W    = 24;
  localparam int unsigned GAIN_FRAC = 23;
  localparam int unsigned ACC_FRAC  = 30;
  // 10^(-0.0125) in Q0.30
  localparam logic [63:0] STEP_RATIO = 64'd1043277569;

  // Linear gain per level, built by repeated multiplication at high precision
  function automatic logic [GAIN_W*NUM_CODES-1:0] build_gain_rom();
    logic [GAIN_W*NUM_CODES-1:0] rom;
    logic [63:0] acc;
    rom = '0;
    acc = 64'd1 << ACC_FRAC;
    for (int c = 0; c < int'(NUM_CODES); c++) begin
      rom[c*GAIN_W +: GAIN_W] =
        GAIN_W'((acc + (64'd1 << (ACC_FRAC - GAIN_FRAC - 1))) >> (ACC_FRAC - GAIN_FRAC));
      acc = (acc * STEP_RATIO + (64'd1 << (ACC_FRAC - 1))) >> ACC_FRAC;
    end
    return rom;
  endfunction
endpackage

// File: rtl/atten_gain_rom.sv
module atten_gain_rom
  import soft_atten_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W*NUM_CODES-1:0] ROM = build_gain_rom();

  // top level bit marks mute
  assign gain_o = lvl_i[LVL_W-1] ? '0 : ROM[lvl_i[CODE_W-1:0]*GAIN_W +: GAIN_W];
endmodule

// File: rtl/atten_ramp.sv
module atten_ramp #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned MAX_SHIFT = 4,
  localparam int unsigned LVL_W    = CODE_W + 1,
  localparam int unsigned CNT_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [LVL_W-1:0]  lvl_nxt_o,
  output logic              done_o
);
  localparam logic [LVL_W-1:0] MUTE_LVL = LVL_W'(1) << CODE_W;

  logic [LVL_W-1:0] lvl_q, lvl_d, tgt;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  assign tgt = (&code_i) ? MUTE_LVL : {1'b0, code_i};

  always_comb begin
    int sh;
    sh = int'(rate_i) - 1;
    if (sh > int'(MAX_SHIFT)) sh = int'(MAX_SHIFT);
    if (sh < 0) sh = 0;
    last = CNT_W'((32'd1 << sh) - 32'd1);
  end

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (step_i) begin
      if (rate_i == '0) begin
        lvl_d = tgt;
        cnt_d = '0;
      end else if (lvl_q == tgt) begin
        cnt_d = '0;
      end else if (cnt_q >= last) begin
        cnt_d = '0;
        lvl_d = (lvl_q < tgt) ? lvl_q + 1'b1 : lvl_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o     = lvl_q;
  assign lvl_nxt_o = lvl_d;
  assign done_o    = (lvl_q == tgt);
endmodule

// File: rtl/atten_mult.sv
module atten_mult #(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned GAIN_W    = 24,
  parameter int unsigned GAIN_FRAC = 23,
  localparam int unsigned PW       = DATA_W + GAIN_W + 1
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [GAIN_W-1:0] gain_i,
  output logic signed [DATA_W-1:0] result_o
);
  localparam logic signed [PW-1:0] RND_HALF =
    {{(PW-GAIN_FRAC){1'b0}}, 1'b1, {(GAIN_FRAC-1){1'b0}}};
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] s_ext, g_ext, prod, rnd;

  assign s_ext = {{(PW-DATA_W){sample_i[DATA_W-1]}}, sample_i};
  assign g_ext = {{(PW-GAIN_W){1'b0}}, gain_i};
  assign prod  = s_ext * g_ext;
  assign rnd   = (prod + RND_HALF) >>> GAIN_FRAC;

  always_comb begin
    if (rnd > SAT_HI)      result_o = SAT_HI[DATA_W-1:0];
    else if (rnd < SAT_LO) result_o = SAT_LO[DATA_W-1:0];
    else                   result_o = rnd[DATA_W-1:0];
  end
endmodule

// File: rtl/soft_atten.sv
module soft_atten
  import soft_atten_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned RATE_W    = 3,
  parameter int unsigned MAX_SHIFT = 4,
  localparam int unsigned NCH      = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0]        atten_i,
  input  logic [RATE_W-1:0]        rate_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic                     done_o
);
  logic [LVL_W-1:0]  lvl_q, lvl_nxt;
  logic [GAIN_W-1:0] gain;
  logic signed [DATA_W-1:0] smp_in  [NCH];
  logic signed [DATA_W-1:0] smp_out [NCH];

  atten_ramp #(
    .CODE_W(CODE_W), .RATE_W(RATE_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_ramp (
    .clk_i, .rst_ni,
    .step_i   (valid_i),
    .code_i   (atten_i),
    .rate_i   (rate_i),
    .lvl_o    (lvl_q),
    .lvl_nxt_o(lvl_nxt),
    .done_o   (done_o)
  );

  // sample on a stepping strobe already sees the new level
  atten_gain_rom u_rom (.lvl_i(lvl_nxt), .gain_o(gain));

  assign smp_in[0] = left_i;
  assign smp_in[1] = right_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    atten_mult #(
      .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_mult (
      .sample_i(smp_in[ch]),
      .gain_i  (gain),
      .result_o(smp_out[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        left_o  <= smp_out[0];
        right_o <= smp_out[1];
      end
    end
  end
endmodule

// File: rtl/soft_atten_chk.sv
module soft_atten_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned RATE_W = 3,
  parameter int unsigned LVL_W  = CODE_W + 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] left_i,
  input logic signed [DATA_W-1:0] right_i,
  input logic [CODE_W-1:0]        atten_i,
  input logic [RATE_W-1:0]        rate_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] left_o,
  input logic signed [DATA_W-1:0] right_o,
  input logic                     done_o,
  input logic [LVL_W-1:0]         lvl_q
);
  localparam logic [LVL_W-1:0] MUTE_LVL = LVL_W'(1) << CODE_W;

  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && atten_i == '0 && rate_i == '0 |=>
      left_o == $past(left_i) && right_o == $past(right_i)) else $error("AST_UNITY_PASS"); // R1

  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (&atten_i) && rate_i == '0 |=> left_o == '0 && right_o == '0)
    else $error("AST_MUTE_ZERO"); // R2

  AST_IMMEDIATE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rate_i == '0 |=>
      lvl_q == ((&$past(atten_i)) ? MUTE_LVL : {1'b0, $past(atten_i)}))
    else $error("AST_IMMEDIATE_SET"); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rate_i != '0 |=>
      (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 1'b1 || lvl_q + 1'b1 == $past(lvl_q)))
    else $error("AST_SINGLE_STEP"); // R5

  AST_CHANNEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && left_i == right_i |=> left_o == right_o) else $error("AST_CHANNEL_MATCH"); // R8

  AST_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rate_i == '0 && $stable(atten_i) |=> done_o || !$stable(atten_i))
    else $error("AST_DONE_FLAG"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(lvl_q) && $stable(left_o) && $stable(right_o))
    else $error("AST_IDLE_HOLD"); // R10
endmodule

bind soft_atten soft_atten_chk #(
  .DATA_W(DATA_W), .CODE_W(soft_atten_pkg::CODE_W), .RATE_W(RATE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
  .atten_i(atten_i), .rate_i(rate_i), .valid_o(valid_o), .left_o(left_o),
  .right_o(right_o), .done_o(done_o), .lvl_q(lvl_q)
);

// File: tb/soft_atten_test.sv
module soft_atten_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [23:0] left_i = '0, right_i = '0;
  logic [7:0] atten_i = '0;
  logic [2:0] rate_i = '0;
  logic valid_o, done_o;
  logic signed [23:0] left_o, right_o;

  int n_chk = 0, n_fail = 0;
  int lvl_m = 0, cnt_m = 0;
  int exp_l = 0, exp_r = 0, tol_l = 0, tol_r = 0;
  bit exp_v = 0;
  string tag_l = "R1", tag_r = "R1";

  always #2 clk = ~clk;

  soft_atten uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .left_i(left_i), .right_i(right_i),
    .atten_i(atten_i), .rate_i(rate_i), .valid_o(valid_o), .left_o(left_o),
    .right_o(right_o), .done_o(done_o)
  );

  task automatic check(string req, int act, int exp, int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tgt_of(int a);
    return (a == 255) ? 256 : a;
  endfunction

  function automatic int scale(int x, int lvl);
    real y;
    int q;
    if (lvl >= 256) return 0;
    y = real'(x) * (10.0 ** (-real'(lvl) / 80.0));
    q = $rtoi($floor(y + 0.5));
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  function automatic string tag_for(int lvl);
    if (lvl == 0) return "R1";
    if (lvl >= 256) return "R2";
    return "R3";
  endfunction

  function automatic int tol_for(int x, int lvl);
    if (lvl == 0 || lvl >= 256) return 0;
    if (x < 4096 && x > -4096) return 0;
    return 3;
  endfunction

  // drive one cycle, starting and ending at a falling edge
  task automatic tick(bit v, int l, int r, int a, int rt);
    int t, d;
    valid_i = v; left_i = 24'(l); right_i = 24'(r);
    atten_i = 8'(a); rate_i = 3'(rt);
    #1;
    check("R9 done", int'(done_o), int'(lvl_m == tgt_of(a)), 0);
    if (v) begin
      t = tgt_of(a);
      d = 1 << (((rt > 5) ? 5 : rt) - 1 < 0 ? 0 : ((rt > 5) ? 5 : rt) - 1);
      if (rt == 0) begin
        lvl_m = t; cnt_m = 0;
      end else if (lvl_m == t) begin
        cnt_m = 0;
      end else if (cnt_m >= d - 1) begin
        cnt_m = 0;
        lvl_m = (lvl_m < t) ? lvl_m + 1 : lvl_m - 1;
      end else begin
        cnt_m++;
      end
      exp_l = scale(l, lvl_m); tol_l = tol_for(l, lvl_m); tag_l = tag_for(lvl_m);
      exp_r = scale(r, lvl_m); tol_r = tol_for(r, lvl_m); tag_r = tag_for(lvl_m);
    end
    exp_v = v;
    @(posedge clk);
    @(negedge clk);
    check("R10 valid", int'(valid_o), int'(exp_v), 0);
    check({tag_l, " left"}, int'(left_o), exp_l, tol_l);
    check({tag_r, " right"}, int'(right_o), exp_r, tol_r);
    if (v && l == r) check("R8 same gain", int'(left_o), int'(right_o), 0);
  endtask

  function automatic int pat(int i);
    return ((i * 1103515245 + 12345) >>> 8) % 8000000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(valid_o), 0, 0);
    check("R10 reset left", int'(left_o), 0, 0);
    #1;
    check("R9 reset done", int'(done_o), 1, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unity, full-scale extremes
    tick(1, 8388607, -8388608, 0, 0);
    tick(1, -8388608, 8388607, 0, 0);
    for (int i = 0; i < 6; i++) tick(1, pat(i), pat(i + 50), 0, 0);

    // R11 rounding on small values: -6 dB and -20 dB
    tick(1, 1, -1, 24, 0);
    check("R11 round pos", int'(left_o), 1, 0);
    check("R11 round neg", int'(right_o), -1, 0);
    tick(1, 3, -3, 80, 0);
    check("R11 round small", int'(left_o), 0, 0);

    // R4 immediate jumps, R2 mute
    tick(1, 4000000, 4000000, 40, 0);
    tick(1, 5000000, -5000000, 255, 0);
    check("R2 mute left", int'(left_o), 0, 0);
    tick(1, 7000000, 7000000, 0, 0);
    check("R4 immediate unity", int'(left_o), 7000000, 0);

    // R10 idle cycles between samples hold everything
    tick(0, 123, 456, 12, 1);
    tick(0, 789, 1, 12, 1);
    check("R10 hold", int'(left_o), 7000000, 0);

    // R5 ramp at dwell 1 and dwell 2 with strobe gaps
    for (int i = 0; i < 14; i++) tick(1, pat(i + 7), pat(i + 7), 12, 1);
    for (int i = 0; i < 20; i++) tick(i % 3 != 0, pat(i + 30), -pat(i + 31), 4, 2);

    // R6 walk into mute: (256-250)*4 = 24 strobes
    tick(1, 100, 100, 250, 0);
    n = 0;
    while (n < 200) begin
      tick(1, pat(n + 90), pat(n + 91), 255, 3);
      n++;
      if (done_o) break;
    end
    check("R6 mute walk strobes", n, 24, 0);
    check("R2 mute reached", int'(left_o), 0, 0);

    // R5 codes 6 and 7 behave as dwell 16: 10 -> 12 takes 32
    tick(1, 100, 100, 10, 0);
    n = 0;
    while (n < 200) begin
      tick(1, pat(n), pat(n + 3), 12, (n < 16) ? 7 : 6);
      n++;
      if (done_o) break;
    end
    check("R5 dwell 16", n, 32, 0);

    // R7 retarget mid-walk, and rate drop below reached dwell count
    tick(1, 100, 100, 0, 0);
    for (int i = 0; i < 10; i++) tick(1, pat(i + 200), pat(i + 201), 100, 1);
    for (int i = 0; i < 3; i++) tick(1, pat(i + 220), pat(i + 220), 2, 4);
    for (int i = 0; i < 30; i++) tick(1, pat(i + 240), pat(i + 241), 2, 1);
    check("R7 back at target", int'(done_o), 1, 0);

    // R3 sweep across the whole table at dwell 1
    tick(1, 100, 100, 0, 0);
    for (int i = 0; i < 260; i++) tick(1, 8000000, -8000000, 254, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule